// File: doc/BRIEF.md
# Six-Channel Timer Bank with Watchdog Reset Request

This block holds six independent 16-bit up-counters. A pulse input at the 32 kHz rate drives all of them. Each counter advances through its own power-of-two divider of that pulse. Every counter has four registers on a small synchronous register bus: a setup word, the live count and two compare values.

The setup word is write-once. Its first write fixes the divider selection for good. After that, only the run bit and the two compare-event flags respond to writes, and the flags are cleared by writing ones. A setup word that reads as zero marks a counter as unused, and the block reports those counters on a separate output so that software can claim one. One shared control word holds, for each counter, a reset-request enable and an NMI-request enable. When a counter reaches its second compare value while the matching enable is set, the block raises a one-cycle request pulse. A typical use is a watchdog: the counter is stopped, cleared and restarted before it can reach the limit.

Top module: `mft_bank`

## Requirements
- R1: After reset every register reads zero, `free_mask` is all ones and both request outputs are low.
- R2: The first write to a setup word stores the divider select (bits 3:0) for good. Later writes leave bits 3:0 unchanged. Bits 12:4 always read zero.
- R3: After lock, setup bit 15 (run) still follows every write. Writing 1 to bit 13 clears the compare-1 event flag, writing 1 to bit 14 clears the compare-2 event flag, and writing 0 to either bit leaves that flag unchanged.
- R4: `free_mask[i]` is high exactly when counter i's setup word reads zero.
- R5: A running counter with divider select s advances by one on every 2^s-th `tick_32k` pulse after reset, counted by one divider chain shared by all counters. A stopped counter holds its value.
- R6: A write to the count register takes effect only while the run bit is 0. It is ignored while the counter runs.
- R7: A compare event flag (setup bit 13 for compare 1, bit 14 for compare 2) sets on the advance that makes the count equal to that compare value. A hardware set takes priority over a clear in the same cycle.
- R8: The count saturates at 0xFFFF and does not wrap.
- R9: `rst_req` is a one-cycle pulse in the same cycle that counter i's compare-2 flag first reads 1, if control bit i is set. It does not pulse again while that flag stays set.
- R10: `nmi_req` behaves the same way as `rst_req`, but uses control bit 8+i.
- R11: Address bits 5:3 select the counter and bits 2:0 select the register (0 compare 1, 1 compare 2, 2 count, 3 setup). Address 0x38 is the control word. Every other address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle pulse at the 32 kHz base rate |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| free_mask | output | 6 | One bit per counter whose setup word is zero |
| rst_req | output | 1 | Reset request pulse |
| nmi_req | output | 1 | NMI request pulse |

## Verification
Most internal errors reach the ports within one clock. A setup field that unlocks, or a flag that fails to clear, changes the setup readback on the cycle after the write. A counter on the wrong divider phase first shows a wrong count on the first qualifying tick. A wrong compare or request condition shows up on the advance that reaches the compare value: the request pulse is missing or extra, or it lasts longer than one cycle, on the same edge at which the flag readback changes. A lost saturation shows up one advance after 0xFFFF.

// File: rtl/mft_pkg.sv
`timescale 1ns/1ps
package mft_pkg;
    localparam int NUM_TMR    = 6;
    localparam int CNT_W      = 16;
    localparam int PSEL_W     = 4;
    localparam int PRE_W      = 15;
    localparam int OFS_W      = 3;
    localparam int IDX_W      = 3;
    localparam int ADDR_W     = IDX_W + OFS_W;
    // setup word bit positions
    localparam int SU_RUN     = 15;
    localparam int SU_EV2     = 14;
    localparam int SU_EV1     = 13;
    // control word field bases; counter i sits at base + i
    localparam int RSTEN_BASE = 0;
    localparam int NMIEN_BASE = 8;
    localparam logic [IDX_W-1:0] CTL_SLOT = 3'd7;

    typedef enum logic [OFS_W-1:0] {
        OFS_CMP1  = 3'd0,
        OFS_CMP2  = 3'd1,
        OFS_CNT   = 3'd2,
        OFS_SETUP = 3'd3
    } reg_ofs_e;
endpackage

// File: rtl/mft_prescale.sv
`timescale 1ns/1ps
module mft_prescale
    import mft_pkg::*;
#(
    parameter int NT  = NUM_TMR,
    parameter int SW  = PSEL_W,
    parameter int PW  = PRE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NT-1:0][SW-1:0] psel,
    output logic [NT-1:0]        adv
);
    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (tick) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // a counter advances when the low 'psel' bits of the shared chain are all ones
    for (genvar i = 0; i < NT; i++) begin : g_adv
        logic [PW-1:0] mask;
        always_comb begin
            for (int j = 0; j < PW; j++) mask[j] = (j < int'(psel[i]));
            adv[i] = tick && ((pre_q & mask) == mask);
        end
    end
endmodule

// File: rtl/mft_timer.sv
`timescale 1ns/1ps
module mft_timer
    import mft_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = PSEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          wr_cmp1,
    input  logic          wr_cmp2,
    input  logic          wr_cnt,
    input  logic          wr_setup,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] setup_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cmp1_o,
    output logic [CW-1:0] cmp2_o,
    output logic [SW-1:0] psel_o,
    output logic          ev2_new_o
);
    typedef struct packed {
        logic          locked;
        logic          run;
        logic          ev1;
        logic          ev2;
        logic [SW-1:0] psel;
        logic [CW-1:0] cnt;
        logic [CW-1:0] c1;
        logic [CW-1:0] c2;
    } tmr_t;

    tmr_t          d, q;
    logic [CW-1:0] nxt;

    always_comb begin
        d         = q;
        nxt       = q.cnt + 1'b1;
        ev2_new_o = 1'b0;
        if (wr_setup) begin
            if (!q.locked) begin
                d.locked = 1'b1;
                d.psel   = wdata[SW-1:0];
            end
            d.run = wdata[SU_RUN];
            if (wdata[SU_EV1]) d.ev1 = 1'b0;
            if (wdata[SU_EV2]) d.ev2 = 1'b0;
        end
        if (wr_cmp1) d.c1 = wdata;
        if (wr_cmp2) d.c2 = wdata;
        if (wr_cnt && !q.run) d.cnt = wdata;
        if (q.run && adv && (q.cnt != '1)) begin
            d.cnt = nxt;
            if (nxt == q.c1) d.ev1 = 1'b1;
            if (nxt == q.c2) begin
                d.ev2     = 1'b1;
                ev2_new_o = !q.ev2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        setup_o           = '0;
        setup_o[SW-1:0]   = q.psel;
        setup_o[SU_RUN]   = q.run;
        setup_o[SU_EV2]   = q.ev2;
        setup_o[SU_EV1]   = q.ev1;
    end

    assign cnt_o  = q.cnt;
    assign cmp1_o = q.c1;
    assign cmp2_o = q.c2;
    assign psel_o = q.psel;
endmodule

// File: rtl/mft_bank.sv
`timescale 1ns/1ps
module mft_bank
    import mft_pkg::*;
#(
    parameter int NT = NUM_TMR,
    parameter int CW = CNT_W,
    parameter int SW = PSEL_W,
    parameter int PW = PRE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_32k,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NT-1:0] free_mask,
    output logic          rst_req,
    output logic          nmi_req
);
    typedef struct packed {
        logic [NT-1:0] rsten;
        logic [NT-1:0] nmien;
        logic          rst_req;
        logic          nmi_req;
    } ctl_t;

    ctl_t                  ctl_d, ctl_q;
    logic [IDX_W-1:0]      slot;
    reg_ofs_e              ofs;
    logic                  ctl_hit;
    logic [NT-1:0]         adv, ev2_new;
    logic [NT-1:0][SW-1:0] psel;
    logic [NT-1:0][CW-1:0] setup_rd, cnt_rd, cmp1_rd, cmp2_rd;
    logic [NT-1:0]         rst_en_vec, nmi_en_vec;

    assign slot    = bus_addr[AW-1:OFS_W];
    assign ofs     = reg_ofs_e'(bus_addr[OFS_W-1:0]);
    assign ctl_hit = (slot == CTL_SLOT) && (bus_addr[OFS_W-1:0] == '0);

    mft_prescale #(.NT(NT), .SW(SW), .PW(PW)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_32k),
        .psel (psel),
        .adv  (adv)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        localparam logic [IDX_W-1:0] MY_SLOT = IDX_W'(i);
        logic sel;
        assign sel = bus_wr && (slot == MY_SLOT);
        mft_timer #(.CW(CW), .SW(SW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv[i]),
            .wr_cmp1  (sel && (ofs == OFS_CMP1)),
            .wr_cmp2  (sel && (ofs == OFS_CMP2)),
            .wr_cnt   (sel && (ofs == OFS_CNT)),
            .wr_setup (sel && (ofs == OFS_SETUP)),
            .wdata    (bus_wdata),
            .setup_o  (setup_rd[i]),
            .cnt_o    (cnt_rd[i]),
            .cmp1_o   (cmp1_rd[i]),
            .cmp2_o   (cmp2_rd[i]),
            .psel_o   (psel[i]),
            .ev2_new_o(ev2_new[i])
        );
        assign free_mask[i] = (setup_rd[i] == '0);
    end

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr && ctl_hit) begin
            ctl_d.rsten = bus_wdata[RSTEN_BASE +: NT];
            ctl_d.nmien = bus_wdata[NMIEN_BASE +: NT];
        end
        ctl_d.rst_req = |(ev2_new & ctl_q.rsten);
        ctl_d.nmi_req = |(ev2_new & ctl_q.nmien);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (ctl_hit) begin
            bus_rdata[RSTEN_BASE +: NT] = ctl_q.rsten;
            bus_rdata[NMIEN_BASE +: NT] = ctl_q.nmien;
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (slot == IDX_W'(i)) begin
                    case (ofs)
                        OFS_CMP1:  bus_rdata = cmp1_rd[i];
                        OFS_CMP2:  bus_rdata = cmp2_rd[i];
                        OFS_CNT:   bus_rdata = cnt_rd[i];
                        OFS_SETUP: bus_rdata = setup_rd[i];
                        default:   bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign rst_en_vec = ctl_q.rsten;
    assign nmi_en_vec = ctl_q.nmien;
    assign rst_req    = ctl_q.rst_req;
    assign nmi_req    = ctl_q.nmi_req;
endmodule

// File: rtl/mft_bank_chk.sv
`timescale 1ns/1ps
module mft_bank_chk
    import mft_pkg::*;
#(
    parameter int NT = NUM_TMR,
    parameter int CW = CNT_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  rst_req,
    input logic                  nmi_req,
    input logic [NT-1:0][CW-1:0] setup_rd,
    input logic [NT-1:0][CW-1:0] cnt_rd,
    input logic [NT-1:0]         rst_en_vec,
    input logic [NT-1:0]         nmi_en_vec
);
    logic [NT-1:0] ev2_vec;
    always_comb for (int i = 0; i < NT; i++) ev2_vec[i] = setup_rd[i][SU_EV2];

    AST_RST_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ((ev2_vec & rst_en_vec) != '0)); // R9
    AST_RST_NEW_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ((ev2_vec & rst_en_vec) != $past(ev2_vec & rst_en_vec))); // R9
    AST_NMI_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> ((ev2_vec & nmi_en_vec) != '0)); // R10

    for (genvar i = 0; i < NT; i++) begin : g_chk
        AST_PSEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(setup_rd[i][PSEL_W-1:0]) != '0) |-> $stable(setup_rd[i][PSEL_W-1:0])); // R2
        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(cnt_rd[i]) && !$past(bus_wr)) |-> (cnt_rd[i] == $past(cnt_rd[i]) + 1'b1)); // R5
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(cnt_rd[i]) == '1) && !$past(bus_wr)) |-> (cnt_rd[i] == '1)); // R8
    end
endmodule

bind mft_bank mft_bank_chk #(.NT(NT), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .rst_req   (rst_req),
    .nmi_req   (nmi_req),
    .setup_rd  (setup_rd),
    .cnt_rd    (cnt_rd),
    .rst_en_vec(rst_en_vec),
    .nmi_en_vec(nmi_en_vec)
);

// File: tb/mft_bank_test.sv
`timescale 1ns/1ps
module mft_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [5:0]  free_mask;
    logic        rst_req, nmi_req;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    mft_bank uut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .free_mask(free_mask), .rst_req(rst_req), .nmi_req(nmi_req)
    );

    function automatic logic [5:0] ra(int t, int o);
        return {t[2:0], o[2:0]};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; tick_32k = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [5:0] a, logic [15:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic tick1();
        tick_32k = 1'b1;
        @(negedge clk);
        tick_32k = 1'b0;
    endtask

    task automatic idle1();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        for (int t = 0; t < 6; t++)
            for (int o = 0; o < 4; o++) rd("R1 reg zero", ra(t, o), 16'h0000);
        rd("R1 ctl zero", 6'h38, 16'h0000);
        chk("R1/R4 free_mask", {10'h0, free_mask}, 16'h003F);
        chk("R1 rst_req", {15'h0, rst_req}, 16'h0);
        chk("R1 nmi_req", {15'h0, nmi_req}, 16'h0);
    endtask

    task automatic t_lock();
        do_reset();
        wr(ra(2, 3), 16'h8005);
        rd("R2 first write", ra(2, 3), 16'h8005);
        chk("R4 free after write", {10'h0, free_mask}, 16'h003B);
        wr(ra(2, 3), 16'h0003);
        rd("R2/R3 psel kept, run cleared", ra(2, 3), 16'h0005);
        wr(ra(2, 3), 16'h8FFF);
        rd("R2 reserved zero, run set", ra(2, 3), 16'h8005);
        wr(ra(2, 4), 16'hFFFF);
        rd("R11 hole reads zero", ra(2, 4), 16'h0000);
        rd("R11 slot6 reads zero", 6'h30, 16'h0000);
        rd("R11 hole write no effect", ra(2, 0), 16'h0000);
    endtask

    task automatic t_prescale();
        do_reset();
        wr(ra(1, 3), 16'h0000);
        wr(ra(0, 3), 16'h8002);
        chk("R4 zero setup still free", {10'h0, free_mask}, 16'h003E);
        for (int k = 0; k < 3; k++) tick1();
        rd("R5 no advance before 4th tick", ra(0, 2), 16'h0000);
        tick1();
        rd("R5 advance on 4th tick", ra(0, 2), 16'h0001);
        for (int k = 0; k < 4; k++) tick1();
        rd("R5 advance on 8th tick", ra(0, 2), 16'h0002);
        rd("R5 stopped counter holds", ra(1, 2), 16'h0000);
    endtask

    task automatic t_cnt_write();
        do_reset();
        wr(ra(3, 2), 16'h1234);
        rd("R6 write while stopped", ra(3, 2), 16'h1234);
        wr(ra(3, 3), 16'h8000);
        wr(ra(3, 2), 16'h0000);
        rd("R6 write while running ignored", ra(3, 2), 16'h1234);
        tick1();
        rd("R5/R6 run from written value", ra(3, 2), 16'h1235);
    endtask

    task automatic t_compare_sat();
        do_reset();
        wr(ra(4, 0), 16'd3);
        wr(ra(4, 1), 16'd5);
        wr(ra(4, 3), 16'h8000);
        tick1(); tick1();
        rd("R7 no flag before match", ra(4, 3), 16'h8000);
        tick1();
        rd("R7 cmp1 flag", ra(4, 3), 16'hA000);
        tick1(); tick1();
        rd("R7 cmp2 flag", ra(4, 3), 16'hE000);
        rd("R7 count at cmp2", ra(4, 2), 16'd5);
        wr(ra(4, 3), 16'hE000);
        rd("R3 write-one clears flags", ra(4, 3), 16'h8000);
        wr(ra(4, 3), 16'h0000);
        wr(ra(4, 2), 16'hFFFE);
        wr(ra(4, 3), 16'h8000);
        tick1();
        rd("R8 reach max", ra(4, 2), 16'hFFFF);
        tick1();
        rd("R8 saturate", ra(4, 2), 16'hFFFF);
    endtask

    task automatic t_requests();
        do_reset();
        wr(6'h38, 16'h0220);
        rd("R11 control readback", 6'h38, 16'h0220);
        wr(ra(1, 1), 16'd1);
        wr(ra(1, 3), 16'h8000);
        tick1();
        chk("R10 nmi pulse", {15'h0, nmi_req}, 16'h1);
        chk("R9 no rst for timer1", {15'h0, rst_req}, 16'h0);
        idle1();
        chk("R10 nmi one cycle", {15'h0, nmi_req}, 16'h0);
        wr(ra(1, 3), 16'h4000);
        wr(ra(5, 1), 16'd2);
        wr(ra(5, 3), 16'h8000);
        tick1();
        chk("R9 no early rst", {15'h0, rst_req}, 16'h0);
        tick1();
        chk("R9 rst pulse", {15'h0, rst_req}, 16'h1);
        chk("R10 no nmi for timer5", {15'h0, nmi_req}, 16'h0);
        rd("R9 flag with pulse", ra(5, 3), 16'hC000);
        idle1();
        chk("R9 rst one cycle", {15'h0, rst_req}, 16'h0);
        wr(ra(5, 3), 16'h0000);
        wr(ra(5, 2), 16'h0000);
        wr(ra(5, 3), 16'h8000);
        tick1(); tick1();
        chk("R9 no refire while flag set", {15'h0, rst_req}, 16'h0);
        wr(ra(5, 3), 16'h4000);
        wr(ra(5, 2), 16'h0000);
        wr(ra(5, 3), 16'h8000);
        tick1(); tick1();
        chk("R9 refire after clear", {15'h0, rst_req}, 16'h1);
    endtask

    initial begin
        t_reset_state();
        t_lock();
        t_prescale();
        t_cnt_write();
        t_compare_sat();
        t_requests();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule